// File: doc/BRIEF.md
# Programmable PRBS Pattern Generator

This block produces a serial pseudo-random test stream for link and bit-error-rate testing. A 32-bit shift register advances one position on every enabled clock. Its new bit is the XOR of every register bit selected by a run-time tap mask, so the mask alone sets both the polynomial and the effective register length. Any polynomial of degree up to 32 can be produced, and a primitive one gives a sequence of up to 2^32 - 1 bits before it repeats.

A seed word is copied into the register when the load strobe goes from low to high. A zero seed would freeze the generator, so it is replaced by all ones. The optional QRSS mode ignores the tap mask and uses the fixed degree-20 polynomial x^20 + x^17 + 1. In that mode the output runs 14 bits behind the register, which lets the block see ahead of the bit it is about to send. Any bit followed by 14 zeros is sent as a 1. When the clock enable is low, the register, the lookahead history and the output all hold their values, so the line keeps the last bit sent.

Top module: `prbs_pattern_gen`

## Requirements
- R1: A synchronous active-low reset sets the shift register to all ones, clears the 14-bit lookahead history and drives `dout` low.
- R2: In plain mode, each enabled clock (`clk_en` high and no load edge) computes the new bit b as the XOR of `state & tap_mask`. The state becomes `{state[30:0], b}`, and `dout` takes b at that same edge.
- R3: While `clk_en` is low and no load edge occurs, the state, the history and `dout` keep their values.
- R4: A rising edge of `load` is a cycle with `load` high that follows a cycle with `load` low, the cycle after reset counting as low. On that edge the state takes `seed` and the history clears, whatever `clk_en` is, and `dout` is unchanged. While `load` stays high, no further load occurs.
- R5: A load edge with `seed` equal to zero sets the state to all ones instead.
- R6: While `qrss_en` is high, the feedback uses only state bits 19 and 16 (x^20 + x^17 + 1), and `tap_mask` has no effect.
- R7: The history h holds the last 14 new bits. An enabled clock forms w = {h, b}. When `qrss_en` is high, `dout` takes w[14] OR (w[13:0] == 0). The history always updates to w[13:0], in both modes.
- R8: A primitive tap mask of degree n gives a sequence with period 2^n - 1. For mask 0x14 (x^5 + x^3 + 1), the output repeats every 31 bits and holds 16 ones per period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | Advances the generator by one bit when high |
| tap_mask | input | 32 | Feedback tap selection, bit k taps state bit k |
| seed | input | 32 | Value loaded into the shift register |
| load | input | 1 | Load strobe, acts on its rising edge |
| qrss_en | input | 1 | Selects the fixed degree-20 polynomial with zero suppression |
| dout | output | 1 | Serial pattern bit |

## Verification
A wrong bit in the shift register shows up on `dout` within the number of enabled clocks it takes that bit to reach a selected tap. For a low tap, that is a single cycle. It then keeps corrupting the stream, because the feedback carries the error forward. An error in the history appears only in QRSS mode. It shows 14 enabled clocks later as a wrong delayed bit, or sooner as a missing or spurious forced 1. A wrong load-edge detector shows on the first output after the strobe: a missed reload, or a second reload while the strobe stays high.

// File: rtl/prbs_pkg.sv
// Package: shared types and helpers for the PRBS pattern generator.
// Assumes: nothing beyond IEEE 1800-2017 semantics.
package prbs_pkg;

    // Output selection mode of the generator.
    typedef enum logic {
        MODE_PLAIN = 1'b0,
        MODE_QRSS  = 1'b1
    } prbs_mode_e;

    // Builds a two-tap feedback mask for x^deg + x^tap + 1 within a 64-bit word.
    function automatic logic [63:0] two_tap_mask(input int unsigned deg, input int unsigned tap);
        logic [63:0] m;
        m = '0;
        m[deg - 1] = 1'b1;
        m[tap - 1] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/prbs_load_ctl.sv
// Module: detects the rising edge of the load strobe and sanitises the seed.
// Assumes: load is synchronous to clk; a zero seed is replaced by all ones
// so the shift register can never start in the locked all-zero state.
module prbs_load_ctl #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] seed,
    output logic             load_pulse,
    output logic [WIDTH-1:0] seed_safe
);

    logic load_q;

    // Registered copy of the strobe for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q <= 1'b0;
        end else begin
            load_q <= load;
        end
    end

    // Rising edge: strobe high now, low on the previous cycle.
    always_comb begin
        load_pulse = load & ~load_q;
    end

    // Zero seed is replaced with all ones.
    always_comb begin
        seed_safe = (seed == '0) ? '1 : seed;
    end

endmodule

// File: rtl/prbs_lfsr_core.sv
// Module: Fibonacci shift register with a run-time tap mask.
// Assumes: tap_eff already holds the taps for the active mode; load has
// priority over stepping; the new bit enters at bit 0.
module prbs_lfsr_core #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             load_pulse,
    input  logic [WIDTH-1:0] seed_safe,
    input  logic [WIDTH-1:0] tap_eff,
    output logic [WIDTH-1:0] state,
    output logic             fb
);

    // Feedback: parity of all tapped state bits.
    always_comb begin
        fb = ^(state & tap_eff);
    end

    // State update: reset, load, or shift with feedback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= '1;
        end else if (load_pulse) begin
            state <= seed_safe;
        end else if (step) begin
            state <= {state[WIDTH-2:0], fb};
        end
    end

endmodule

// File: rtl/prbs_qrss_window.sv
// Module: lookahead history and output register with QRSS zero suppression.
// Assumes: raw is the bit the register produces on this step; in QRSS mode
// the output lags by ZERO_RUN steps so the following ZERO_RUN bits are known.
module prbs_qrss_window
    import prbs_pkg::*;
#(
    parameter int unsigned ZERO_RUN = 14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    input  logic       load_pulse,
    input  logic       raw,
    input  prbs_mode_e mode,
    output logic       dout
);

    localparam int unsigned WIN = ZERO_RUN + 1;

    logic [ZERO_RUN-1:0] hist;
    logic [WIN-1:0]      win;
    logic                zero_ahead;
    logic                next_bit;

    // Window of the delayed bit plus the ZERO_RUN bits that follow it.
    always_comb begin
        win        = {hist, raw};
        zero_ahead = (win[ZERO_RUN-1:0] == '0);
    end

    // Output bit for this step in the selected mode.
    always_comb begin
        if (mode == MODE_QRSS) begin
            next_bit = win[WIN-1] | zero_ahead;
        end else begin
            next_bit = raw;
        end
    end

    // History shift; cleared on reset and on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
        end else if (load_pulse) begin
            hist <= '0;
        end else if (step) begin
            hist <= win[ZERO_RUN-1:0];
        end
    end

    // Output register; holds when not stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= 1'b0;
        end else if (step) begin
            dout <= next_bit;
        end
    end

endmodule

// File: rtl/prbs_pattern_gen.sv
// Module: top of the programmable PRBS pattern generator.
// Assumes: WIDTH >= QRSS_DEGREE > QRSS_TAP >= 1; every input is synchronous
// to clk; one output bit per enabled clock.
module prbs_pattern_gen
    import prbs_pkg::*;
#(
    parameter int unsigned WIDTH       = 32,
    parameter int unsigned QRSS_DEGREE = 20,
    parameter int unsigned QRSS_TAP    = 17,
    parameter int unsigned ZERO_RUN    = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic [WIDTH-1:0] tap_mask,
    input  logic [WIDTH-1:0] seed,
    input  logic             load,
    input  logic             qrss_en,
    output logic             dout
);

    localparam logic [63:0]      QRSS_MASK_WIDE = two_tap_mask(QRSS_DEGREE, QRSS_TAP);
    localparam logic [WIDTH-1:0] QRSS_MASK      = QRSS_MASK_WIDE[WIDTH-1:0];

    logic             load_pulse;
    logic [WIDTH-1:0] seed_safe;
    logic [WIDTH-1:0] tap_eff;
    logic [WIDTH-1:0] lfsr_state;
    logic             fb_bit;
    logic             step;
    prbs_mode_e       mode;

    // Mode decode and effective tap mask.
    always_comb begin
        mode    = qrss_en ? MODE_QRSS : MODE_PLAIN;
        tap_eff = (mode == MODE_QRSS) ? QRSS_MASK : tap_mask;
    end

    // Advance only on enabled cycles that are not load cycles.
    always_comb begin
        step = clk_en & ~load_pulse;
    end

    prbs_load_ctl #(.WIDTH(WIDTH)) u_load (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .seed       (seed),
        .load_pulse (load_pulse),
        .seed_safe  (seed_safe)
    );

    prbs_lfsr_core #(.WIDTH(WIDTH)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .load_pulse (load_pulse),
        .seed_safe  (seed_safe),
        .tap_eff    (tap_eff),
        .state      (lfsr_state),
        .fb         (fb_bit)
    );

    prbs_qrss_window #(.ZERO_RUN(ZERO_RUN)) u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .load_pulse (load_pulse),
        .raw        (fb_bit),
        .mode       (mode),
        .dout       (dout)
    );

endmodule

// File: rtl/prbs_pattern_gen_chk.sv
// Module: assertion checker bound to prbs_pattern_gen.
// Assumes: observes the top ports and the shift-register state only.
module prbs_pattern_gen_chk #(
    parameter int unsigned WIDTH    = 32,
    parameter int unsigned ZERO_RUN = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clk_en,
    input logic [WIDTH-1:0] seed,
    input logic             load,
    input logic             qrss_en,
    input logic             dout,
    input logic [WIDTH-1:0] state
);

    logic       load_prev;
    logic       ld_edge;
    logic       upd_q;
    logic       qrss_q;
    logic [5:0] zrun;

    // Own copy of the strobe history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_prev <= 1'b0;
            upd_q     <= 1'b0;
            qrss_q    <= 1'b0;
        end else begin
            load_prev <= load;
            upd_q     <= clk_en & ~ld_edge;
            qrss_q    <= qrss_en;
        end
    end

    always_comb begin
        ld_edge = load & ~load_prev;
    end

    // Length of the current run of zeros emitted in QRSS mode.
    always_ff @(posedge clk) begin
        if (!rst_n || ld_edge) begin
            zrun <= '0;
        end else if (upd_q) begin
            if (!qrss_q || dout) begin
                zrun <= '0;
            end else if (zrun != '1) begin
                zrun <= zrun + 6'd1;
            end
        end
    end

    AST_SHIFT_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !ld_edge) |=> (state[WIDTH-1:1] == $past(state[WIDTH-2:0]))); // R2

    AST_IDLE_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en && !ld_edge) |=> $stable(state)); // R3

    AST_IDLE_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en && !ld_edge) |=> $stable(dout)); // R3

    AST_SEED_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_edge && seed != '0) |=> (state == $past(seed))); // R4

    AST_LOAD_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ld_edge |=> $stable(dout)); // R4

    AST_ZERO_SEED_FIX: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_edge && seed == '0) |=> (state == '1)); // R5

    AST_QRSS_ZERO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (zrun <= 6'(ZERO_RUN))); // R7

endmodule

bind prbs_pattern_gen prbs_pattern_gen_chk #(
    .WIDTH    (WIDTH),
    .ZERO_RUN (ZERO_RUN)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clk_en  (clk_en),
    .seed    (seed),
    .load    (load),
    .qrss_en (qrss_en),
    .dout    (dout),
    .state   (lfsr_state)
);

// File: tb/tb_prbs_pattern_gen.sv
module tb_prbs_pattern_gen;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 32;
    localparam logic [W-1:0] QMASK = 32'h0009_0000;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         clk_en;
    logic [W-1:0] tap_mask;
    logic [W-1:0] seed;
    logic         load;
    logic         qrss_en;
    logic         dout;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // Reference model state
    logic [W-1:0] m_s;
    logic [13:0]  m_h;
    logic         m_dout;
    logic         m_lq;

    always #(CLK_PERIOD/2) clk = ~clk;

    prbs_pattern_gen dut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .tap_mask(tap_mask),
        .seed(seed), .load(load), .qrss_en(qrss_en), .dout(dout)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: dout actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_s = '1; m_h = '0; m_dout = 1'b0; m_lq = 1'b0;
    endtask

    // One enabled-or-not clock of the reference, from the requirements.
    function automatic string model_step(input logic en, input logic ld, input logic qr,
                                         input logic [W-1:0] msk, input logic [W-1:0] sd);
        logic lp, b;
        logic [14:0] w;
        string tag;
        lp = ld & ~m_lq;
        m_lq = ld;
        if (lp) begin
            m_s = (sd == '0) ? '1 : sd;
            m_h = '0;
            tag = (sd == '0) ? "R5" : "R4";
        end else if (en) begin
            b = ^(m_s & (qr ? QMASK : msk));
            m_s = {m_s[W-2:0], b};
            w = {m_h, b};
            m_dout = qr ? (w[14] | (w[13:0] == '0)) : b;
            m_h = w[13:0];
            tag = qr ? "R7" : "R2";
        end else begin
            tag = "R3";
        end
        return tag;
    endfunction

    // Drive at the falling edge, let one rising edge pass, compare at the next falling edge.
    task automatic cyc(input logic en, input logic ld, input logic qr,
                       input logic [W-1:0] msk, input logic [W-1:0] sd, input string tag);
        string t;
        clk_en = en; load = ld; qrss_en = qr; tap_mask = msk; seed = sd;
        t = model_step(en, ld, qr, msk, sd);
        @(posedge clk);
        @(negedge clk);
        check((tag == "") ? t : tag, dout, m_dout);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic bits [0:61];
        logic qa [0:29];
        logic ld_r, qr_r;
        logic [W-1:0] msk_r;
        int ones;
        bit same;
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0; clk_en = 1'b0; load = 1'b0; qrss_en = 1'b0;
        tap_mask = '0; seed = '0;
        model_reset();
        repeat (3) @(negedge clk);
        check("R1", dout, 1'b0);
        rst_n = 1'b1;

        // R1: from the all-ones reset state, mask bit 0 only feeds back 1s
        for (int i = 0; i < 4; i++) cyc(1, 0, 0, 32'h1, 32'h0, "R1");
        // R1: reset state ones seen through tap 31
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 32'h8000_0000, 32'h0, "R1");

        // R4: load a seed, then hold the strobe high (no reload)
        cyc(0, 0, 0, 32'h60, 32'h0000_0055, "R4");
        cyc(1, 1, 0, 32'h60, 32'h0000_0055, "R4");
        for (int i = 0; i < 10; i++) cyc(1, 1, 0, 32'h60, 32'h0000_0055, "R4");
        // R4: load while clock disabled
        cyc(0, 0, 0, 32'h60, 32'h1234_5678, "R4");
        cyc(0, 1, 0, 32'h60, 32'h1234_5678, "R4");
        for (int i = 0; i < 6; i++) cyc(1, 0, 0, 32'h60, 32'h1234_5678, "R4");

        // R3: clock enable low holds the output
        for (int i = 0; i < 8; i++) cyc(0, 0, 0, 32'h60, 32'h0, "R3");

        // R5: zero seed with mask bit 0 gives a stream of ones
        cyc(1, 1, 0, 32'h1, 32'h0, "R5");
        for (int i = 0; i < 5; i++) begin
            cyc(1, 0, 0, 32'h1, 32'h0, "R5");
            check("R5", dout, 1'b1);
        end

        // R8: x^5+x^3+1 period 31, 16 ones
        cyc(1, 0, 0, 32'h14, 32'h1, "R8");
        cyc(1, 1, 0, 32'h14, 32'h1, "R8");
        for (int i = 0; i < 62; i++) begin
            cyc(1, 0, 0, 32'h14, 32'h1, "R8");
            bits[i] = dout;
        end
        same = 1; ones = 0;
        for (int i = 0; i < 31; i++) begin
            if (bits[i] !== bits[i+31]) same = 0;
            if (bits[i] === 1'b1) ones++;
        end
        check("R8", same, 1'b1);
        n_checks++;
        if (ones != 16) begin
            n_fail++;
            $display("FAIL R8: ones per period actual=%0d expected=16", ones);
        end

        // R7: lower 20 bits zero in QRSS mode -> raw zeros, output forced to 1
        cyc(1, 0, 1, 32'hFFFF_FFFF, 32'h0010_0000, "R7");
        cyc(1, 1, 1, 32'hFFFF_FFFF, 32'h0010_0000, "R7");
        for (int i = 0; i < 40; i++) begin
            cyc(1, 0, 1, 32'hFFFF_FFFF, 32'h0010_0000, "R7");
            check("R7", dout, 1'b1);
        end
        // R2: same state in plain mode with QRSS taps gives raw zeros
        cyc(1, 0, 0, 32'h0, 32'h0010_0000, "R2");
        cyc(1, 1, 0, QMASK, 32'h0010_0000, "R2");
        for (int i = 0; i < 20; i++) begin
            cyc(1, 0, 0, QMASK, 32'h0010_0000, "R2");
            check("R2", dout, 1'b0);
        end

        // R6: tap mask has no effect in QRSS mode
        cyc(1, 0, 1, 32'h0000_0003, 32'hACE1_0357, "R6");
        cyc(1, 1, 1, 32'h0000_0003, 32'hACE1_0357, "R6");
        for (int i = 0; i < 30; i++) begin
            cyc(1, 0, 1, 32'h0000_0003, 32'hACE1_0357, "R6");
            qa[i] = dout;
        end
        cyc(1, 0, 1, 32'h8000_0001, 32'hACE1_0357, "R6");
        cyc(1, 1, 1, 32'h8000_0001, 32'hACE1_0357, "R6");
        same = 1;
        for (int i = 0; i < 30; i++) begin
            cyc(1, 0, 1, 32'h8000_0001, 32'hACE1_0357, "R6");
            if (dout !== qa[i]) same = 0;
        end
        check("R6", same, 1'b1);

        // Random mix of all inputs
        ld_r = 0; qr_r = 0; msk_r = 32'h60;
        for (int i = 0; i < 5000; i++) begin
            logic en;
            logic [W-1:0] sd;
            en = ($urandom % 4) != 0;
            if (($urandom % 16) == 0) ld_r = ~ld_r;
            if (($urandom % 128) == 0) qr_r = ~qr_r;
            if (($urandom % 64) == 0) begin
                case ($urandom % 5)
                    0: msk_r = 32'h0000_0060;
                    1: msk_r = 32'h0000_6000;
                    2: msk_r = 32'h0042_0000;
                    3: msk_r = 32'h4800_0000;
                    default: msk_r = $urandom;
                endcase
            end
            sd = (($urandom % 8) == 0) ? 32'h0 : $urandom;
            cyc(en, ld_r, qr_r, msk_r, sd, "");
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    end

endmodule